// File: doc/BRIEF.md
# Chainable Event Counter Bank

A bank of eight 32-bit counters that tally event codes arriving from cache logic, each code carried on an 8-bit bus with a valid strobe. Every counter has a selector register that names the code it counts. A selector holding the cycles code (0x01) makes the counter advance on every clock, whether or not the strobe is valid. Software controls the block through a single-cycle register port. That port holds a global run bit and a clear-all bit, per-counter enable set and clear masks, writable counter values, sticky wrap flags and per-counter saturate bits.

An even counter and the odd counter directly above it can be joined into one 64-bit count. The odd counter's bit in the chain register is set for this. The odd counter then ignores its own selector and enable, and advances exactly when the even counter wraps. A 64-bit count is cleared by writing zero to both counters. The usual event codes are cycles 0x01, read hit 0x20, read miss 0x21, dirty read hit 0x22, dirty read miss 0x23, write hit 0x24 and write miss 0x25. Any 8-bit code can be selected.

Top module: `evcnt_bank`

## Requirements
- R1: After reset every register reads zero: control, chain, enable mask, wrap flags, saturate bits, selectors and counters.
- R2: A counter advances by one on a clock edge when the run bit is 1, its enable bit is 1, it is not a chained odd counter, and either its selector is 0x01 or the strobe is valid with a code equal to its selector. Otherwise it holds.
- R3: A selector write stores only data bits 7:0. A read returns those 8 bits with zeros above them.
- R4: In the control register (byte offset 0x00), bit 0 is the run bit and reads back. Writing 1 to bit 1 zeroes all eight counters on that edge, and bit 1 always reads 0.
- R5: Writing the enable-set register (0x08) ORs the data into the enable mask. Writing the enable-clear register (0x0C) removes every mask bit written as 1. Bits written as 0 leave the mask unchanged. Both offsets read the current mask.
- R6: The chain register (0x04) stores only odd bit positions, and even positions read 0. Bit k (k odd) joins counter k to counter k-1, so a read-modify-write that sets one bit keeps the others.
- R7: A chained odd counter advances once on each edge where its even partner wraps from 0xFFFFFFFF to 0. It ignores its own selector and enable bit.
- R8: The wrap-flag register (0x10) bit k is set when counter k rolls from 0xFFFFFFFF to 0. Writing 1 to a bit clears it, a wrap in the same cycle wins over the clear, and a chained odd counter flags only on a full 64-bit wrap.
- R9: Counter k is written at byte offset 0x40+4k. That write takes the full 32 bits and replaces any advance in the same cycle.
- R10: The saturate register (0x14) resets to 0, which means rollover. With bit k set, counter k stops at 0xFFFFFFFF, sets no wrap flag and passes no carry to a chained partner.
- R11: Selector k is at byte offset 0x20+4k. Accesses with address bits 1:0 nonzero, and word offsets outside the map, change nothing and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe for this cycle |
| addr | input | 8 | Byte address of the register access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for addr, combinational |
| ev_valid | input | 1 | Event code valid this cycle |
| ev_code | input | 8 | Event code |

## Verification
A register write or an event seen in a cycle takes effect at the next rising edge. Because reads are combinational, the new value is already on rd_data in the low phase that follows. A chained odd counter moves on the same edge as its partner's wrap, not one cycle later. The bench drives every input at the falling edge and samples rd_data one nanosecond later. Its reference model steps exactly once per rising edge, read cycles included, so counters selecting 0x01 stay in step with the model.

// File: rtl/evcnt_bank.sv
`timescale 1ns/1ps
module evcnt_bank #(
  parameter int NC = 8,
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int EW = 8
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          ev_valid,
  input  logic [EW-1:0] ev_code
);
  localparam int WAW = AW - 2;
  localparam logic [WAW-1:0] A_CTRL = WAW'(0);
  localparam logic [WAW-1:0] A_GANG = WAW'(1);
  localparam logic [WAW-1:0] A_ENS  = WAW'(2);
  localparam logic [WAW-1:0] A_ENC  = WAW'(3);
  localparam logic [WAW-1:0] A_OVF  = WAW'(4);
  localparam logic [WAW-1:0] A_SAT  = WAW'(5);
  localparam int EVT_BASE = 8;
  localparam int CNT_BASE = 16;
  localparam logic [DW-1:0] CMAX = '1;
  localparam logic [EW-1:0] EV_CYCLES = EW'(1);

  function automatic logic [NC-1:0] odd_bits();
    logic [NC-1:0] r;
    for (int k = 0; k < NC; k++) r[k] = (k % 2 == 1);
    return r;
  endfunction
  localparam logic [NC-1:0] ODDM = odd_bits();

  logic [WAW-1:0] wa;
  logic           aligned, wr_ok;
  logic           wr_ctrl, wr_gang, wr_ens, wr_enc, wr_ovf, wr_sat, clr_all;
  logic           run;
  logic [NC-1:0]  en, gang, ovf, sat, wrap;
  logic [DW-1:0]  cnt [NC];
  logic [EW-1:0]  sel [NC];

  assign wa      = addr[AW-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign wr_ok   = wr_en && aligned;
  assign wr_ctrl = wr_ok && wa == A_CTRL;
  assign wr_gang = wr_ok && wa == A_GANG;
  assign wr_ens  = wr_ok && wa == A_ENS;
  assign wr_enc  = wr_ok && wa == A_ENC;
  assign wr_ovf  = wr_ok && wa == A_OVF;
  assign wr_sat  = wr_ok && wa == A_SAT;
  assign clr_all = wr_ctrl && wr_data[1];

  for (genvar i = 0; i < NC; i++) begin : g_ctr
    logic own, up, w, at_max, hit_cnt, hit_sel;
    assign at_max  = (cnt[i] == CMAX);
    assign own     = run && en[i] && (sel[i] == EV_CYCLES || (ev_valid && ev_code == sel[i]));
    if (i % 2 == 1) begin : g_odd
      assign up = gang[i] ? g_ctr[i-1].w : own;
    end else begin : g_even
      assign up = own;
    end
    assign w       = up && at_max && !sat[i];
    assign wrap[i] = w;
    assign hit_cnt = wr_ok && wa == WAW'(CNT_BASE + i);
    assign hit_sel = wr_ok && wa == WAW'(EVT_BASE + i);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                      cnt[i] <= '0;
      else if (clr_all)                cnt[i] <= '0;
      else if (hit_cnt)                cnt[i] <= wr_data;
      else if (up && !(sat[i] && at_max)) cnt[i] <= cnt[i] + 1'b1;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       sel[i] <= '0;
      else if (hit_sel) sel[i] <= wr_data[EW-1:0];

    // R2: without a register write a counter moves by at most one step
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (cnt[i] == $past(cnt[i]) || cnt[i] == $past(cnt[i]) + 1'b1));

    // R10: a saturating counter at its ceiling stays there
    a_r10_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && sat[i] && cnt[i] == CMAX) |=> cnt[i] == CMAX);

    // R8: a wrap flag drops only after a write-one to the flag register
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ovf[i]) |-> $past(wr_ovf && wr_data[i]));

    if (i % 2 == 1) begin : g_chk_odd
      // R7: chained odd counter holds unless the partner sits at its ceiling
      a_r7_chain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && gang[i] && cnt[i-1] != CMAX) |=> $stable(cnt[i]));
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run  <= 1'b0;
      en   <= '0;
      gang <= '0;
      ovf  <= '0;
      sat  <= '0;
    end else begin
      if (wr_ctrl) run  <= wr_data[0];
      if (wr_gang) gang <= wr_data[NC-1:0] & ODDM;
      if (wr_ens)  en   <= en | wr_data[NC-1:0];
      if (wr_enc)  en   <= en & ~wr_data[NC-1:0];
      if (wr_sat)  sat  <= wr_data[NC-1:0];
      ovf <= (ovf & ~(wr_ovf ? wr_data[NC-1:0] : '0)) | wrap;
    end

  // R5: the enable mask changes only through its two write offsets
  a_r5_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ens || wr_enc) |=> $stable(en));

  always_comb begin
    rd_data = '0;
    if (aligned) begin
      case (wa)
        A_CTRL:       rd_data[0]      = run;
        A_GANG:       rd_data[NC-1:0] = gang;
        A_ENS, A_ENC: rd_data[NC-1:0] = en;
        A_OVF:        rd_data[NC-1:0] = ovf;
        A_SAT:        rd_data[NC-1:0] = sat;
        default:
          for (int k = 0; k < NC; k++) begin
            if (wa == WAW'(EVT_BASE + k)) rd_data[EW-1:0] = sel[k];
            if (wa == WAW'(CNT_BASE + k)) rd_data = cnt[k];
          end
      endcase
    end
  end
endmodule

// File: tb/test_evcnt_bank.sv
`timescale 1ns/1ps
module test_evcnt_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        ev_valid = 1'b0;
  logic [7:0]  ev_code = '0;

  int nchk = 0;
  int nerr = 0;

  logic        m_run;
  logic [7:0]  m_en, m_gang, m_ovf, m_sat;
  logic [31:0] m_cnt [8];
  logic [7:0]  m_sel [8];

  evcnt_bank i_evcnt_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .ev_valid(ev_valid), .ev_code(ev_code)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] model_read(logic [7:0] a);
    int w;
    w = int'(a[7:2]);
    if (a[1:0] != 2'b00) return 32'h0;
    case (w)
      0: return {31'h0, m_run};
      1: return {24'h0, m_gang};
      2, 3: return {24'h0, m_en};
      4: return {24'h0, m_ovf};
      5: return {24'h0, m_sat};
      default: begin
        if (w >= 8 && w < 16) return {24'h0, m_sel[w-8]};
        if (w >= 16 && w < 24) return m_cnt[w-16];
        return 32'h0;
      end
    endcase
  endfunction

  function automatic void model_step(logic we, logic [7:0] a, logic [31:0] d, logic v, logic [7:0] c);
    logic [7:0]  up, wr, clrm;
    logic [31:0] nxt [8];
    logic        ok;
    int          w;
    for (int i = 0; i < 8; i++) begin
      if (i % 2 == 1 && m_gang[i]) up[i] = wr[i-1];
      else up[i] = m_run && m_en[i] && (m_sel[i] == 8'h01 || (v && c == m_sel[i]));
      wr[i]  = up[i] && m_cnt[i] == 32'hFFFF_FFFF && !m_sat[i];
      nxt[i] = (up[i] && !(m_sat[i] && m_cnt[i] == 32'hFFFF_FFFF)) ? m_cnt[i] + 1 : m_cnt[i];
    end
    ok = we && a[1:0] == 2'b00;
    w  = int'(a[7:2]);
    clrm = (ok && w == 4) ? d[7:0] : 8'h0;
    m_ovf = (m_ovf & ~clrm) | wr;
    if (ok) begin
      if (w >= 16 && w < 24) nxt[w-16] = d;
      if (w >= 8 && w < 16) m_sel[w-8] = d[7:0];
      case (w)
        0: begin
          m_run = d[0];
          if (d[1]) for (int i = 0; i < 8; i++) nxt[i] = 32'h0;
        end
        1: m_gang = d[7:0] & 8'hAA;
        2: m_en = m_en | d[7:0];
        3: m_en = m_en & ~d[7:0];
        5: m_sat = d[7:0];
        default: ;
      endcase
    end
    for (int i = 0; i < 8; i++) m_cnt[i] = nxt[i];
  endfunction

  task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d,
                     input logic v, input logic [7:0] c);
    @(negedge clk);
    wr_en = we; addr = a; wr_data = d; ev_valid = v; ev_code = c;
    model_step(we, a, d, v, c);
    @(posedge clk);
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string req);
    @(negedge clk);
    wr_en = 1'b0; addr = a; wr_data = '0; ev_valid = 1'b0; ev_code = '0;
    #1;
    nchk++;
    if (rd_data !== e) begin
      nerr++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, rd_data, e);
    end
    model_step(1'b0, a, 32'h0, 1'b0, 8'h0);
    @(posedge clk);
  endtask

  task automatic chk(input logic [7:0] a, input string req);
    expect_rd(a, model_read(a), req);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, 8'h0);
  endtask

  task automatic ev(input logic [7:0] c, input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 8'h0, 32'h0, 1'b1, c);
  endtask

  initial begin
    #800000;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] codes [8];
    int seed;
    codes = '{8'h01, 8'h20, 8'h21, 8'h22, 8'h23, 8'h24, 8'h25, 8'h7E};
    seed = $urandom(32'd1957);
    m_run = 0; m_en = 0; m_gang = 0; m_ovf = 0; m_sat = 0;
    for (int i = 0; i < 8; i++) begin m_cnt[i] = 0; m_sel[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    expect_rd(8'h00, 32'h0, "R1");
    expect_rd(8'h04, 32'h0, "R1");
    expect_rd(8'h08, 32'h0, "R1");
    expect_rd(8'h10, 32'h0, "R1");
    expect_rd(8'h14, 32'h0, "R1");
    expect_rd(8'h20, 32'h0, "R1");
    expect_rd(8'h40, 32'h0, "R1");
    expect_rd(8'h5C, 32'h0, "R1");

    // R3 selector width
    wr(8'h20, 32'hABCD_1220);
    expect_rd(8'h20, 32'h20, "R3");
    wr(8'h24, 32'h21); wr(8'h28, 32'h01); wr(8'h2C, 32'h22);
    wr(8'h30, 32'hFFFF_FF24); wr(8'h34, 32'h25); wr(8'h38, 32'h23); wr(8'h3C, 32'h20);
    expect_rd(8'h30, 32'h24, "R3");

    // R5 enable mask
    wr(8'h08, 32'hBF);
    wr(8'h0C, 32'h42);
    expect_rd(8'h08, 32'hBD, "R5");
    expect_rd(8'h0C, 32'hBD, "R5");
    wr(8'h08, 32'h40);
    expect_rd(8'h0C, 32'hFD, "R5");
    wr(8'h0C, 32'h40);

    // R2 counting
    wr(8'h00, 32'h1);
    expect_rd(8'h00, 32'h1, "R4");
    ev(8'h20, 3);
    ev(8'h21, 2);
    cyc(1'b0, 8'h0, 32'h0, 1'b0, 8'h20);
    expect_rd(8'h40, 32'd3, "R2");
    expect_rd(8'h44, 32'd0, "R2");
    expect_rd(8'h5C, 32'd3, "R2");
    chk(8'h48, "R2");

    // R6 chain register
    wr(8'h04, 32'h02);
    expect_rd(8'h04, 32'h02, "R6");
    wr(8'h04, 32'h0A);
    expect_rd(8'h04, 32'h0A, "R6");
    wr(8'h04, 32'h0F);
    expect_rd(8'h04, 32'h0A, "R6");

    // R7 chained pair
    wr(8'h40, 32'hFFFF_FFFE);
    wr(8'h44, 32'd5);
    ev(8'h21, 1);
    expect_rd(8'h44, 32'd5, "R7");
    ev(8'h20, 3);
    expect_rd(8'h40, 32'd1, "R7");
    expect_rd(8'h44, 32'd6, "R7");
    expect_rd(8'h10, 32'h01, "R8");
    chk(8'h4C, "R7");

    // R8 64-bit wrap and clearing
    wr(8'h10, 32'h01);
    expect_rd(8'h10, 32'h0, "R8");
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h44, 32'hFFFF_FFFF);
    ev(8'h20, 1);
    expect_rd(8'h40, 32'h0, "R8");
    expect_rd(8'h44, 32'h0, "R8");
    expect_rd(8'h10, 32'h03, "R8");
    wr(8'h10, 32'h01);
    expect_rd(8'h10, 32'h02, "R8");

    // R10 saturation
    wr(8'h14, 32'h10);
    wr(8'h50, 32'hFFFF_FFFE);
    ev(8'h24, 3);
    expect_rd(8'h50, 32'hFFFF_FFFF, "R10");
    expect_rd(8'h10, 32'h02, "R10");
    wr(8'h14, 32'h0);
    ev(8'h24, 1);
    expect_rd(8'h50, 32'h0, "R10");
    expect_rd(8'h10, 32'h12, "R10");

    // R9 writes override advances
    wr(8'h48, 32'd100);
    expect_rd(8'h48, 32'd100, "R9");
    expect_rd(8'h48, 32'd101, "R9");
    cyc(1'b1, 8'h40, 32'd7, 1'b1, 8'h20);
    expect_rd(8'h40, 32'd7, "R9");

    // R4 clear-all and stop
    wr(8'h00, 32'h3);
    expect_rd(8'h48, 32'h0, "R4");
    expect_rd(8'h00, 32'h1, "R4");
    wr(8'h00, 32'h0);
    chk(8'h48, "R4");
    ev(8'h20, 2);
    chk(8'h48, "R4");
    expect_rd(8'h40, 32'h0, "R4");

    // R11 unmapped and misaligned
    wr(8'h18, 32'hFFFF_FFFF);
    expect_rd(8'h18, 32'h0, "R11");
    wr(8'h41, 32'h55);
    expect_rd(8'h41, 32'h0, "R11");
    expect_rd(8'h40, 32'h0, "R11");
    wr(8'h7C, 32'h1234);
    expect_rd(8'h7C, 32'h0, "R11");
    chk(8'h00, "R11");

    // random traffic
    wr(8'h00, 32'h1);
    wr(8'h08, 32'hFF);
    for (int n = 0; n < 4000; n++) begin
      int w;
      logic [7:0]  a;
      logic [31:0] d;
      w = int'($urandom % 26);
      a = 8'(w * 4) | (($urandom % 16 == 0) ? 8'h1 : 8'h0);
      if ($urandom % 4 == 0) begin
        chk(a, (w >= 16 && w < 24) ? "R2" : "R8");
      end else begin
        d = $urandom;
        if (w >= 16 && w < 24 && $urandom % 2 == 0) d = 32'hFFFF_FFFF - ($urandom % 4);
        if (w == 0) d = {30'h0, ($urandom % 16 == 0), 1'b1};
        if (w == 3) d = d & 32'h11;
        cyc(($urandom % 8 == 0), a, d, ($urandom % 4 != 0), codes[$urandom % 8]);
      end
    end
    for (int k = 0; k < 24; k++) chk(8'(k * 4), "R7");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule